// File: doc/BRIEF.md
# Idle-Mode Descrambler State Recovery

This receiver block rebuilds the 33-bit descrambler state of one wire pair from the lower-band symbols sent during idle. For each received symbol it gets a strobe, an amplitude class (small or large point) and a sign decision. A small point means a descrambler bit of one. A large point means a bit of zero. The first 33 decided bits are loaded straight into a local shift register. From then on that register runs on its own using the selected feedback polynomial. Its predictions are compared with the received bits over a verification window.

The block declares lock only if the mispredictions in the window stay within a budget and the received signs agree with the expected signs in a consistent way. All signs matching means normal polarity. All signs opposite means the pair is inverted, and the polarity flag is set. Once locked, the block keeps tracking the local sequence. It gives up lock after a run of consecutive mispredictions and then acquires again. The recovered state, the lock flag and the polarity flag tell later startup stages when they may begin.

Top module: `idle_desc_recover`

## Requirements
- R1: After a synchronous reset, `locked` is 0, `pol_inv` is 0 and `state_o` is all zeros.
- R2: A received symbol with `sym_big`=1 decodes to bit 0, and one with `sym_big`=0 decodes to bit 1. While acquiring, each decoded bit is shifted into `state_o` at bit 0, older bits move toward bit 32, and after 33 symbols the register holds those 33 bits.
- R3: With `master`=1 the predicted next bit is `state_o[12]` XOR `state_o[32]` (taps x^13, x^33). With `master`=0 it is `state_o[19]` XOR `state_o[32]` (taps x^20, x^33).
- R4: After loading, verification runs for WIN (default 64) symbols. `locked` rises right after the WIN-th symbol if that window held at most MISS_MAX (default 2) mispredictions. Otherwise the block returns to acquisition.
- R5: Outside acquisition, `state_o` advances with its own predicted bit on each symbol, so received bit errors do not alter it.
- R6: The expected sign of a symbol is the scrambler bit sent SIGN_LAG (default 8) symbols earlier, which is `state_o[SIGN_LAG-1]`, with 1 meaning `sym_neg`=1. If every sign in the window is opposite, `pol_inv` is set when lock is declared. If every sign agrees, `pol_inv` is cleared. A mix of the two fails verification.
- R7: While locked, DROP_N (default 4) consecutive mispredictions clear `locked` and restart acquisition. A correct prediction resets the run.
- R8: Cycles with `sym_valid`=0 change nothing, whatever the other inputs carry.
- R9: `pol_inv` changes only at the end of a verification window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master | input | 1 | Polynomial select: 1 = x^13 tap, 0 = x^20 tap |
| sym_valid | input | 1 | A lower-band idle symbol is present this cycle |
| sym_big | input | 1 | Amplitude class: 1 = large point, 0 = small point |
| sym_neg | input | 1 | Sign decision: 1 = negative |
| state_o | output | 33 | Recovered descrambler state, newest bit at bit 0 |
| locked | output | 1 | State verified and being tracked |
| pol_inv | output | 1 | Pair received with inverted polarity |

## Verification
The hardest cases to reach are the edges of the lock decision. These are a window with exactly MISS_MAX errors against one with one more, a run of DROP_N-1 errors against one of DROP_N while locked, and a window where the signs flip partway through. Each needs errors placed on chosen symbols after the load, not during it. The bench models the transmitter's scrambler itself. It can therefore flip the amplitude or sign of a specific symbol in the verification or locked phase, while random gaps of invalid cycles carrying garbage are mixed between the symbols.

// File: rtl/idr_pkg.sv
package idr_pkg;
  typedef enum logic [1:0] {
    PH_ACQ    = 2'd0,
    PH_VERIFY = 2'd1,
    PH_LOCKED = 2'd2
  } idr_phase_e;
endpackage

// File: rtl/idr_lfsr.sv
// Local descrambler shift register: loads received bits or free-runs.
module idr_lfsr #(
  parameter int W        = 33,
  parameter int TAP_M    = 13,
  parameter int TAP_S    = 20,
  parameter int SIGN_LAG = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         master,
  input  logic         shift_en,
  input  logic         use_rx,
  input  logic         rx_bit,
  output logic [W-1:0] state,
  output logic         pred_bit,
  output logic         sign_exp
);
  logic fb_m, fb_s;

  assign fb_m     = state[TAP_M-1] ^ state[W-1];
  assign fb_s     = state[TAP_S-1] ^ state[W-1];
  assign pred_bit = master ? fb_m : fb_s;
  assign sign_exp = state[SIGN_LAG-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
    end else if (shift_en) begin
      state <= {state[W-2:0], (use_rx ? rx_bit : pred_bit)};
    end
  end

  // R8: no strobe, no movement
  assert_lfsr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(state));
  // R5: free-running mode appends the prediction made before the edge
  assert_lfsr_free_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !use_rx) |=> state[W-1:1] == $past(state[W-2:0]));
endmodule

// File: rtl/idr_judge.sv
// Counts mispredictions and opposite signs over one verification window.
module idr_judge #(
  parameter int WIN = 64,
  localparam int JW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic          miss,
  input  logic          opp,
  output logic [JW-1:0] miss_sum,
  output logic [JW-1:0] opp_sum
);
  logic [JW-1:0] miss_cnt, opp_cnt;

  assign miss_sum = miss_cnt + JW'(miss);
  assign opp_sum  = opp_cnt + JW'(opp);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      miss_cnt <= '0;
      opp_cnt  <= '0;
    end else if (step) begin
      miss_cnt <= miss_sum;
      opp_cnt  <= opp_sum;
    end
  end

  // R4: counts never exceed the window length
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt <= JW'(WIN)) && (opp_cnt <= JW'(WIN)));
endmodule

// File: rtl/idle_desc_recover.sv
module idle_desc_recover #(
  parameter int W        = 33,
  parameter int TAP_M    = 13,
  parameter int TAP_S    = 20,
  parameter int SIGN_LAG = 8,
  parameter int WIN      = 64,
  parameter int MISS_MAX = 2,
  parameter int DROP_N   = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         master,
  input  logic         sym_valid,
  input  logic         sym_big,
  input  logic         sym_neg,
  output logic [W-1:0] state_o,
  output logic         locked,
  output logic         pol_inv
);
  import idr_pkg::*;

  localparam int JW   = $clog2(WIN + 1);
  localparam int PMAX = (W > WIN) ? W : WIN;
  localparam int PW   = $clog2(PMAX);
  localparam int RW   = $clog2(DROP_N + 1);

  idr_phase_e    phase;
  logic [PW-1:0] pos;
  logic [RW-1:0] run;
  logic          rx_bit, pred_bit, sign_exp, miss, opp, pass;
  logic [JW-1:0] miss_sum, opp_sum;

  assign rx_bit = ~sym_big;
  assign miss   = pred_bit ^ rx_bit;
  assign opp    = sign_exp ^ sym_neg;

  idr_lfsr #(.W(W), .TAP_M(TAP_M), .TAP_S(TAP_S), .SIGN_LAG(SIGN_LAG)) u_lfsr (
    .clk      (clk),
    .rst      (rst),
    .master   (master),
    .shift_en (sym_valid),
    .use_rx   (phase == PH_ACQ),
    .rx_bit   (rx_bit),
    .state    (state_o),
    .pred_bit (pred_bit),
    .sign_exp (sign_exp)
  );

  idr_judge #(.WIN(WIN)) u_judge (
    .clk      (clk),
    .rst      (rst),
    .clear    (phase != PH_VERIFY),
    .step     (sym_valid && (phase == PH_VERIFY)),
    .miss     (miss),
    .opp      (opp),
    .miss_sum (miss_sum),
    .opp_sum  (opp_sum)
  );

  assign pass = (miss_sum <= JW'(MISS_MAX)) &&
                ((opp_sum == '0) || (opp_sum == JW'(WIN)));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_ACQ;
      pos     <= '0;
      run     <= '0;
      locked  <= 1'b0;
      pol_inv <= 1'b0;
    end else if (sym_valid) begin
      case (phase)
        PH_ACQ: begin
          if (pos == PW'(W - 1)) begin
            phase <= PH_VERIFY;
            pos   <= '0;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        PH_VERIFY: begin
          if (pos == PW'(WIN - 1)) begin
            pos <= '0;
            if (pass) begin
              phase   <= PH_LOCKED;
              locked  <= 1'b1;
              pol_inv <= (opp_sum == JW'(WIN));
              run     <= '0;
            end else begin
              phase <= PH_ACQ;
            end
          end else begin
            pos <= pos + 1'b1;
          end
        end
        PH_LOCKED: begin
          if (miss) begin
            if (run == RW'(DROP_N - 1)) begin
              phase  <= PH_ACQ;
              locked <= 1'b0;
              run    <= '0;
              pos    <= '0;
            end else begin
              run <= run + 1'b1;
            end
          end else begin
            run <= '0;
          end
        end
        default: phase <= PH_ACQ;
      endcase
    end
  end

  // R8: idle cycles leave every output untouched
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> ($stable(locked) && $stable(pol_inv) && $stable(state_o)));
  // R4: lock appears only on a symbol that closes a verification window
  assert_lock_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(phase) == PH_VERIFY) && $past(sym_valid));
  // R7: lock falls only on the last of a run of mispredictions
  assert_drop_run_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(run) == RW'(DROP_N - 1)) && $past(sym_valid));
  // R9: polarity flag moves only when leaving verification
  assert_pol_window_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(pol_inv) |-> ($past(phase) == PH_VERIFY));
endmodule

// File: tb/idle_desc_recover_bench.sv
module idle_desc_recover_bench;
  localparam int W = 33, WIN = 64, MISS_MAX = 2, DROP_N = 4, SIGN_LAG = 8;

  logic clk = 1'b0, rst = 1'b1, master = 1'b1;
  logic sym_valid = 1'b0, sym_big = 1'b0, sym_neg = 1'b0;
  logic [W-1:0] state_o;
  logic locked, pol_inv;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] ts;
  logic tx_master = 1'b1;
  bit done = 0;

  always #4 clk = ~clk;

  idle_desc_recover u_idle_desc_recover (
    .clk(clk), .rst(rst), .master(master), .sym_valid(sym_valid),
    .sym_big(sym_big), .sym_neg(sym_neg), .state_o(state_o),
    .locked(locked), .pol_inv(pol_inv));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic next_bit(input logic [W-1:0] s, input logic m);
    return m ? (s[12] ^ s[32]) : (s[19] ^ s[32]);
  endfunction

  // one symbol from the model transmitter, optional bit error and sign flip
  task automatic send(input logic err, input logic inv);
    logic b;
    b = next_bit(ts, tx_master);
    @(negedge clk);
    sym_valid = 1'b1;
    sym_big   = ~(b ^ err);
    sym_neg   = ts[SIGN_LAG-1] ^ inv;
    ts = {ts[W-2:0], b};
    @(negedge clk);
    sym_valid = 1'b0;
    repeat ($urandom_range(0, 2)) begin
      sym_big = 1'($urandom); sym_neg = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic run(input int n, input logic inv);
    for (int i = 0; i < n; i++) send(1'b0, inv);
  endtask

  task automatic start(input logic m, input logic txm);
    @(negedge clk);
    rst = 1'b1; master = m; tx_master = txm; sym_valid = 1'b0;
    ts = {1'($urandom), $urandom} | 33'h1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    ts = '0;
    start(1'b1, 1'b1);
    chk(locked == 0 && pol_inv == 0 && state_o == 0, "R1 reset", {locked, pol_inv, state_o}, 0);

    // R2/R3/R4: clean master load, lock on the last window symbol exactly
    run(W, 1'b0);
    chk(state_o == ts, "R2 loaded state", state_o, ts);
    run(WIN - 1, 1'b0);
    chk(locked == 0, "R4 not locked before window end", locked, 0);
    run(1, 1'b0);
    chk(locked == 1 && pol_inv == 0, "R4 locked at window end", {locked, pol_inv}, 2'b10);
    chk(state_o == ts, "R3 master tracking", state_o, ts);

    // R7: DROP_N-1 errors then a good one keeps lock; DROP_N errors drop it
    for (int i = 0; i < DROP_N - 1; i++) send(1'b1, 1'b0);
    run(1, 1'b0);
    chk(locked == 1, "R7 short error run keeps lock", locked, 1);
    chk(state_o == ts, "R5 state unaffected by errors", state_o, ts);
    for (int i = 0; i < DROP_N - 1; i++) send(1'b1, 1'b0);
    chk(locked == 1, "R7 still locked at DROP_N-1", locked, 1);
    send(1'b1, 1'b0);
    chk(locked == 0, "R7 lock dropped at DROP_N", locked, 0);

    // R3/R6: slave polynomial with inverted pair
    start(1'b0, 1'b0);
    run(W + WIN, 1'b1);
    chk(locked == 1 && pol_inv == 1, "R6 inverted lock", {locked, pol_inv}, 2'b11);
    chk(state_o == ts, "R3 slave tracking", state_o, ts);
    // R9: polarity stays through locked operation despite sign flips
    run(10, 1'b0);
    chk(pol_inv == 1, "R9 polarity held while locked", pol_inv, 1);

    // R4: exactly MISS_MAX errors in window still locks
    start(1'b1, 1'b1);
    run(W, 1'b0);
    for (int i = 0; i < WIN; i++) send(i == 5 || i == 40, 1'b0);
    chk(locked == 1, "R4 MISS_MAX errors accepted", locked, 1);
    chk(state_o == ts, "R5 state after window errors", state_o, ts);

    // R4: MISS_MAX+1 errors rejects
    start(1'b1, 1'b1);
    run(W, 1'b0);
    for (int i = 0; i < WIN; i++) send(i == 1 || i == 30 || i == 63, 1'b0);
    chk(locked == 0, "R4 MISS_MAX+1 errors rejected", locked, 0);

    // R6: mixed signs reject, R9 pol_inv unchanged
    start(1'b1, 1'b1);
    run(W, 1'b0);
    run(WIN / 2, 1'b1);
    run(WIN / 2, 1'b0);
    chk(locked == 0 && pol_inv == 0, "R6 mixed signs rejected", {locked, pol_inv}, 0);

    // R3: slave data received with master setting never locks
    start(1'b1, 1'b0);
    run(W + WIN, 1'b0);
    chk(locked == 0, "R3 wrong polynomial rejected", locked, 0);

    // random trials, R8 gaps with garbage in every send
    for (int t = 0; t < 6; t++) begin
      logic m, inv;
      m = 1'($urandom); inv = 1'($urandom);
      start(m, m);
      run(W + WIN, inv);
      chk(locked == 1 && pol_inv == inv, "R8 random lock/polarity", {locked, pol_inv}, {1'b1, inv});
      chk(state_o == ts, "R8 random state", state_o, ts);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule